// File: doc/BRIEF.md
# Self-Timed Bit-Serial Adder Element

This block is a processing element that performs one two's-complement addition per handshake, one bit per enabled cycle. While it is idle, a host places two operand words in parallel into local shift registers. The host then raises a start request. Only after that does the element turn on its bit clock, which is modelled here as a clock enable gated from a free-running clock. It runs the operands through a one-bit full adder, lowest bit first, for exactly W enabled cycles. A cycle counter then switches the enable off again.

The element is pipelined by one operation. The sum built during an operation sits in an internal sum register. It moves to the visible result port at the moment the next start request is accepted. The result port therefore always shows the sum of the operation before the current one, and it reads zero until the second operation begins.

Done is high whenever the element is idle. The host may hold start high and let Done act as the enable for the next transaction, which gives back-to-back operations.

Top module: `bitser_pe`

## Requirements
- R1: After synchronous reset, done_o is 1, bit_en_o is 0 and result_o is all zeros.
- R2: load_i while done_o is 1 copies opa_i and opb_i into the operand registers. load_i while done_o is 0 has no effect on the operands. A load in the same cycle as an accepted start supplies the operands for that operation.
- R3: start_i is accepted only in a cycle where done_o is 1. start_i while done_o is 0 has no effect: it changes neither the cycle count nor the done timing.
- R4: In the cycle after acceptance, done_o is 0. bit_en_o is then 1 for exactly W consecutive cycles. done_o returns to 1 in the cycle that follows the last enabled cycle.
- R5: While done_o is 1, bit_en_o is 0 and the internal sum and operand state does not change, except through a load.
- R6: Each operation computes (opa + opb) mod 2^W, with operand bits consumed lowest first. The carry starts at 0 on the first bit of every operation, so a carry out of one operation never leaks into the next.
- R7: result_o changes only on the edge that accepts a start. It then takes the sum of the previously completed operation. For the first operation after reset it shows 0.
- R8: If start_i is held high, the element accepts the next operation in the first cycle where done_o is 1. bit_en_o is then low for exactly one cycle between operations.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock from which the bit enable is gated |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Copy opa_i/opb_i into the operand registers (idle only) |
| opa_i | input | W | First operand word |
| opb_i | input | W | Second operand word |
| start_i | input | 1 | Start request, honoured only while done_o is 1 |
| done_o | output | 1 | High while idle; low during an operation |
| bit_en_o | output | 1 | Gated bit-clock enable, high for W cycles per operation |
| result_o | output | W | Sum of the previous operation (pipelined by one) |

## Verification
The hardest situations to reach from the ports involve stimulus that arrives while an operation is running. A stray load or start in those cycles must leave no trace. The test injects a junk load and a stray start pulse in the middle of a run. Because results are pipelined, it confirms the untouched sum only one operation later. It also checks that the enabled-cycle count is still exactly W. Back-to-back chaining is reached by holding start high while done rises, with a new load in the same idle cycle. That case shows that the one idle cycle both accepts the operands and starts the next run.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } pe_state_e;

    typedef struct packed {
        logic sum;
        logic cout;
    } fa_t;

    function automatic fa_t full_add(input logic a, input logic b, input logic cin);
        fa_t r;
        r.sum  = a ^ b ^ cin;
        r.cout = (a & b) | (a & cin) | (b & cin);
        return r;
    endfunction

    function automatic int cnt_width(input int w);
        return (w > 1) ? $clog2(w) : 1;
    endfunction

endpackage

// File: rtl/sbs_ctrl.sv
module sbs_ctrl
    import sbs_pkg::*;
#(
    parameter int W = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    output logic done_o,
    output logic bit_en_o,
    output logic first_o,
    output logic accept_o
);
    localparam int CW = cnt_width(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    pe_state_e       state_q;
    logic [CW-1:0]   cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        state_q <= ST_RUN;
                        cnt_q   <= '0;
                    end
                end
                ST_RUN: begin
                    if (cnt_q == LAST) begin
                        state_q <= ST_IDLE;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign done_o   = (state_q == ST_IDLE);
    assign bit_en_o = (state_q == ST_RUN);
    assign first_o  = bit_en_o && (cnt_q == '0);
    assign accept_o = done_o && start_i;

    AST_ACCEPT_STARTS_RUN: assert property (@(posedge clk) disable iff (rst)
        (done_o && start_i) |=> (!done_o && bit_en_o && cnt_q == '0)); // R3
    AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (rst)
        (bit_en_o && cnt_q != LAST) |=> (!done_o && cnt_q == $past(cnt_q) + 1'b1)); // R3
    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST); // R4
    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        $rose(done_o) |-> ($past(bit_en_o) && $past(cnt_q) == LAST)); // R4

endmodule

// File: rtl/sbs_operand_cache.sv
module sbs_operand_cache #(
    parameter int W = 16,
    parameter int N = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load_en_i,
    input  logic                shift_en_i,
    input  logic [N-1:0][W-1:0] words_i,
    output logic [N-1:0]        lsb_o
);
    logic [N-1:0][W-1:0] sr_q;

    for (genvar i = 0; i < N; i++) begin : g_opnd
        always_ff @(posedge clk) begin
            if (rst) begin
                sr_q[i] <= '0;
            end else if (load_en_i) begin
                sr_q[i] <= words_i[i];
            end else if (shift_en_i) begin
                sr_q[i] <= {1'b0, sr_q[i][W-1:1]};
            end
        end
        assign lsb_o[i] = sr_q[i][0];
    end

    AST_CACHE_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!load_en_i && !shift_en_i) |=> $stable(sr_q)); // R5
    AST_CACHE_NO_LOAD_BUSY: assert property (@(posedge clk) disable iff (rst)
        !(load_en_i && shift_en_i)); // R2

endmodule

// File: rtl/sbs_serial_adder.sv
module sbs_serial_adder
    import sbs_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         bit_en_i,
    input  logic         first_i,
    input  logic         accept_i,
    input  logic         a_i,
    input  logic         b_i,
    output logic [W-1:0] result_o
);
    logic         carry_q;
    logic [W-1:0] sum_q;
    logic [W-1:0] result_q;
    fa_t          fa;

    always_comb fa = full_add(a_i, b_i, first_i ? 1'b0 : carry_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            carry_q  <= 1'b0;
            sum_q    <= '0;
            result_q <= '0;
        end else begin
            if (bit_en_i) begin
                carry_q <= fa.cout;
                sum_q   <= {fa.sum, sum_q[W-1:1]};
            end
            if (accept_i) begin
                result_q <= sum_q;
            end
        end
    end

    assign result_o = result_q;

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !accept_i |=> $stable(result_q)); // R7
    AST_SUM_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !bit_en_i |=> ($stable(sum_q) && $stable(carry_q))); // R5
    AST_NO_ACCEPT_WHILE_RUN: assert property (@(posedge clk) disable iff (rst)
        !(accept_i && bit_en_i)); // R3

endmodule

// File: rtl/bitser_pe.sv
module bitser_pe #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] opa_i,
    input  logic [W-1:0] opb_i,
    input  logic         start_i,
    output logic         done_o,
    output logic         bit_en_o,
    output logic [W-1:0] result_o
);
    localparam int NOPS = 2;

    logic                   done_w;
    logic                   bit_en_w;
    logic                   first_w;
    logic                   accept_w;
    logic [NOPS-1:0]        lsb_w;
    logic [NOPS-1:0][W-1:0] words_w;

    assign words_w[0] = opa_i;
    assign words_w[1] = opb_i;

    sbs_ctrl #(.W(W)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .done_o   (done_w),
        .bit_en_o (bit_en_w),
        .first_o  (first_w),
        .accept_o (accept_w)
    );

    sbs_operand_cache #(.W(W), .N(NOPS)) u_cache (
        .clk        (clk),
        .rst        (rst),
        .load_en_i  (load_i && done_w),
        .shift_en_i (bit_en_w),
        .words_i    (words_w),
        .lsb_o      (lsb_w)
    );

    sbs_serial_adder #(.W(W)) u_adder (
        .clk      (clk),
        .rst      (rst),
        .bit_en_i (bit_en_w),
        .first_i  (first_w),
        .accept_i (accept_w),
        .a_i      (lsb_w[0]),
        .b_i      (lsb_w[1]),
        .result_o (result_o)
    );

    assign done_o   = done_w;
    assign bit_en_o = bit_en_w;

    AST_IDLE_NO_CLOCK: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !bit_en_o); // R5

endmodule

// File: tb/bitser_pe_bench.sv
module bitser_pe_bench;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         load_i = 1'b0;
    logic [W-1:0] opa_i = '0;
    logic [W-1:0] opb_i = '0;
    logic         start_i = 1'b0;
    logic         done_o;
    logic         bit_en_o;
    logic [W-1:0] result_o;

    int checks = 0;
    int fails  = 0;
    logic [W-1:0] expq[$];
    int en_count = 0;
    logic prev_done = 1'b1;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    bitser_pe #(.W(W)) u_bitser_pe (
        .clk(clk), .rst(rst), .load_i(load_i), .opa_i(opa_i), .opb_i(opb_i),
        .start_i(start_i), .done_o(done_o), .bit_en_o(bit_en_o), .result_o(result_o)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: pops the one-operation-delayed expected sum on every done rise
    always @(negedge clk) begin
        if (!rst) begin
            if (bit_en_o) en_count++;
            if (done_o && bit_en_o) chk(1'b0, "R5 bit_en while idle", 1, 0);
            if (!prev_done && done_o) begin
                chk(en_count == W, "R4 enabled cycles per op", en_count, W);
                en_count = 0;
                if (expq.size() == 0) begin
                    chk(1'b0, "R7 scoreboard empty", 0, 1);
                end else begin
                    logic [W-1:0] e;
                    e = expq.pop_front();
                    chk(result_o == e, "R6/R7 pipelined result", result_o, e);
                end
            end
            prev_done = done_o;
        end
    end

    // mode 0: plain, 1: junk load mid-run (R2), 2: stray start mid-run (R3)
    task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b, input int mode);
        while (!done_o) @(negedge clk);
        load_i = 1'b1; opa_i = a; opb_i = b; start_i = 1'b1;
        expq.push_back(a + b);
        @(negedge clk);
        load_i = 1'b0; start_i = 1'b0;
        chk(!done_o && bit_en_o, "R4 done low after accept", done_o, 0);
        repeat (3) @(negedge clk);
        if (mode == 1) begin
            load_i = 1'b1; opa_i = ~a; opb_i = 16'h5a5a;
            @(negedge clk);
            load_i = 1'b0;
        end else if (mode == 2) begin
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            chk(!done_o, "R3 stray start while busy", done_o, 0);
        end
        while (!done_o) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(done_o == 1'b1, "R1 done after reset", done_o, 1);
        chk(bit_en_o == 1'b0, "R1 bit_en after reset", bit_en_o, 0);
        chk(result_o == '0, "R1 result after reset", result_o, 0);
        expq.push_back('0);
        rst = 1'b0;
        @(negedge clk);

        run_op(16'h0003, 16'h0005, 0);          // R6 simple
        run_op(16'hffff, 16'h0001, 0);          // R6 wrap with carry out
        run_op(16'h0001, 16'h0001, 0);          // R6 carry cleared at first bit
        run_op(16'h8000, 16'h8000, 0);          // R6 two negatives overflow
        run_op(16'h1234, 16'hedcb, 0);          // R6 all ones
        run_op(16'h0f0f, 16'h0101, 1);          // R2 junk load ignored while busy
        run_op(16'h7fff, 16'h0002, 2);          // R3 stray start ignored

        // R2/R5: load while idle without start; nothing runs
        @(negedge clk);
        load_i = 1'b1; opa_i = 16'hc000; opb_i = 16'h0abc;
        @(negedge clk);
        load_i = 1'b0; opa_i = '0; opb_i = '0;
        repeat (4) @(negedge clk);
        chk(!bit_en_o && done_o, "R5 idle after plain load", bit_en_o, 0);
        expq.push_back(16'hcabc);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(!done_o, "R2 start on preloaded operands", done_o, 0);
        while (!done_o) @(negedge clk);

        // R8: chained, start held high, reload in the done cycle
        load_i = 1'b1; opa_i = 16'h0100; opb_i = 16'h0200; start_i = 1'b1;
        expq.push_back(16'h0300);
        @(negedge clk);
        load_i = 1'b0;
        while (!done_o) @(negedge clk);
        load_i = 1'b1; opa_i = 16'hfffe; opb_i = 16'hfffe;
        expq.push_back(16'hfffc);
        @(negedge clk);
        load_i = 1'b0; start_i = 1'b0;
        chk(!done_o && bit_en_o, "R8 back-to-back accept", done_o, 0);
        while (!done_o) @(negedge clk);

        run_op(16'h0000, 16'h0000, 0);          // flush R7 pipeline
        repeat (3) @(negedge clk);
        chk(expq.size() == 1, "R7 scoreboard drained", expq.size(), 1);

        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule